// File: doc/BRIEF.md
# Power-Up and Mute Sequencer

This block sequences the digital side of a two-channel analog volume controller through its start-up, undervoltage and mute phases. From reset it holds the rest of the controller in reset with the outputs hardware-muted for a fixed span. It then starts the offset calibration without any outside request. When the calibrator reports completion, it commands both channel gain codes to zero, which is the software-mute setting, and releases the outputs.

A supply-good flag that drops at any time forces the block back into the reset hold, and the whole sequence runs again once the flag returns. A low level on the active-low mute pin counts only if it lasts a minimum number of cycles. A qualified mute holds the outputs muted and runs another offset calibration. When the pin is released, the outputs return without touching the gain codes, so the previous volume setting comes back. Both spans are cycle counts set by parameters.

Top module: `pwr_mute_seq`

## Requirements
- R1: From reset, and with `supply_ok_i` high, `core_reset_o` and `hw_mute_o` stay high for exactly HOLD_CYCLES cycles. Then `cal_start_o` rises on its own in the cycle after the last hold cycle, with `core_reset_o` low and `hw_mute_o` still high.
- R2: `cal_start_o` is high for one cycle only, in the first cycle of each calibration.
- R3: While a calibration runs, `hw_mute_o` and `gain_lock_o` stay high until `cal_done_i` is seen high at a clock edge.
- R4: When the start-up calibration completes, `gain_zero_o` is high for exactly one cycle. In that same cycle `hw_mute_o` and `gain_lock_o` fall. Receivers of `gain_zero_o` clear both 8-bit gain codes to 0.
- R5: `supply_ok_i` low at a clock edge gives `core_reset_o` and `hw_mute_o` high in the next cycle, whatever state the block was in. When the flag returns, the hold count starts again from zero and lasts the full HOLD_CYCLES.
- R6: In normal operation, `mute_n_i` low at MUTE_MIN_CYCLES consecutive clock edges makes `hw_mute_o` and `cal_start_o` high in the cycle after the last of those edges.
- R7: A low level on `mute_n_i` that lasts fewer than MUTE_MIN_CYCLES consecutive edges is ignored: `hw_mute_o` stays low and `cal_start_o` does not pulse. This holds also when two such short pulses are separated by a single high cycle.
- R8: After a mute-triggered calibration completes, `hw_mute_o` stays high for as long as `mute_n_i` is low. It falls in the cycle after `mute_n_i` is seen high, or at once when the pin was already released when the calibration completed. No `gain_zero_o` pulse is issued on this path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good comparator flag, high when the supplies are in range |
| mute_n_i | input | 1 | Mute request pin, active low |
| cal_done_i | input | 1 | Offset calibration finished |
| hw_mute_o | output | 1 | Disconnect the analog outputs |
| core_reset_o | output | 1 | Hold the rest of the controller in reset |
| gain_lock_o | output | 1 | Refuse gain-code writes |
| cal_start_o | output | 1 | One-cycle request to start offset calibration |
| gain_zero_o | output | 1 | One-cycle command that clears both gain codes |

## Verification
The assertions assume that `supply_ok_i`, `mute_n_i` and `cal_done_i` are already synchronous to `clk`. They also assume that `cal_done_i` is raised only while a calibration is in progress, and never in the same cycle as `cal_start_o`. The bench drives every input one time unit after a rising edge and raises `cal_done_i` only a few cycles into each calibration, for a single cycle. Against a reduced configuration, it sweeps every short mute-pulse width, the qualifying width, and a supply drop at every position in the reset hold, as well as during calibration, normal operation and the muted state.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [2:0] {
        PS_HOLD  = 3'd0,
        PS_PCAL  = 3'd1,
        PS_RUN   = 3'd2,
        PS_MCAL  = 3'd3,
        PS_MUTED = 3'd4
    } pms_state_e;

    typedef struct packed {
        pms_state_e state;
        logic       cal_start;
        logic       gain_zero;
    } pms_regs_t;

endpackage

// File: rtl/pms_span_timer.sv
// Counts enabled cycles; done_o marks the LIMIT-th consecutive enabled cycle.
module pms_span_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic done_o
);
    localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/pms_ctrl.sv
module pms_ctrl
    import pms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic mute_n_i,
    input  logic cal_done_i,
    input  logic hold_done_i,
    input  logic mute_hit_i,
    output logic hold_en_o,
    output logic mute_en_o,
    output logic hw_mute_o,
    output logic core_reset_o,
    output logic gain_lock_o,
    output logic cal_start_o,
    output logic gain_zero_o
);
    pms_regs_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.cal_start = 1'b0;
        r_d.gain_zero = 1'b0;
        if (!supply_ok_i) begin
            r_d.state = PS_HOLD;
        end else begin
            unique case (r_q.state)
                PS_HOLD: begin
                    if (hold_done_i) begin
                        r_d.state     = PS_PCAL;
                        r_d.cal_start = 1'b1;
                    end
                end
                PS_PCAL: begin
                    if (cal_done_i) begin
                        r_d.state     = PS_RUN;
                        r_d.gain_zero = 1'b1;
                    end
                end
                PS_RUN: begin
                    if (mute_hit_i) begin
                        r_d.state     = PS_MCAL;
                        r_d.cal_start = 1'b1;
                    end
                end
                PS_MCAL: begin
                    if (cal_done_i) begin
                        r_d.state = mute_n_i ? PS_RUN : PS_MUTED;
                    end
                end
                PS_MUTED: begin
                    if (mute_n_i) begin
                        r_d.state = PS_RUN;
                    end
                end
                default: r_d.state = PS_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: PS_HOLD, cal_start: 1'b0, gain_zero: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_en_o    = (r_q.state == PS_HOLD) && supply_ok_i;
    assign mute_en_o    = (r_q.state == PS_RUN) && !mute_n_i;
    assign hw_mute_o    = (r_q.state != PS_RUN);
    assign core_reset_o = (r_q.state == PS_HOLD);
    assign gain_lock_o  = (r_q.state == PS_HOLD) || (r_q.state == PS_PCAL)
                       || (r_q.state == PS_MCAL);
    assign cal_start_o  = r_q.cal_start;
    assign gain_zero_o  = r_q.gain_zero;

endmodule

// File: rtl/pwr_mute_seq.sv
module pwr_mute_seq #(
    parameter int unsigned HOLD_CYCLES     = 25_000_000,
    parameter int unsigned MUTE_MIN_CYCLES = 500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic mute_n_i,
    input  logic cal_done_i,
    output logic hw_mute_o,
    output logic core_reset_o,
    output logic gain_lock_o,
    output logic cal_start_o,
    output logic gain_zero_o
);
    logic hold_en, hold_done;
    logic mute_en, mute_hit;

    pms_span_timer #(.LIMIT(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (hold_en),
        .done_o (hold_done)
    );

    pms_span_timer #(.LIMIT(MUTE_MIN_CYCLES)) u_mute (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (mute_en),
        .done_o (mute_hit)
    );

    pms_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok_i  (supply_ok_i),
        .mute_n_i     (mute_n_i),
        .cal_done_i   (cal_done_i),
        .hold_done_i  (hold_done),
        .mute_hit_i   (mute_hit),
        .hold_en_o    (hold_en),
        .mute_en_o    (mute_en),
        .hw_mute_o    (hw_mute_o),
        .core_reset_o (core_reset_o),
        .gain_lock_o  (gain_lock_o),
        .cal_start_o  (cal_start_o),
        .gain_zero_o  (gain_zero_o)
    );

endmodule

// File: rtl/pwr_mute_seq_chk.sv
module pwr_mute_seq_chk #(
    parameter int unsigned HOLD_CYCLES     = 4,
    parameter int unsigned MUTE_MIN_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic mute_n,
    input logic hw_mute,
    input logic core_reset,
    input logic gain_lock,
    input logic cal_start,
    input logic gain_zero
);
    localparam int unsigned HW = $clog2(HOLD_CYCLES + 2);
    localparam int unsigned MW = $clog2(MUTE_MIN_CYCLES + 2);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYCLES);
    localparam logic [HW-1:0] HOLD_SAT = HW'(HOLD_CYCLES + 1);
    localparam logic [MW-1:0] MUTE_V = MW'(MUTE_MIN_CYCLES);
    localparam logic [MW-1:0] MUTE_SAT = MW'(MUTE_MIN_CYCLES + 1);

    logic [HW-1:0] hold_run_q;
    logic [MW-1:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_run_q <= '0;
            low_run_q  <= '0;
        end else begin
            if (core_reset && supply_ok) begin
                hold_run_q <= (hold_run_q == HOLD_SAT) ? hold_run_q : hold_run_q + 1'b1;
            end else begin
                hold_run_q <= '0;
            end
            if (!mute_n && !hw_mute) begin
                low_run_q <= (low_run_q == MUTE_SAT) ? low_run_q : low_run_q + 1'b1;
            end else begin
                low_run_q <= '0;
            end
        end
    end

    assert_hold_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start && $past(core_reset) |-> hold_run_q == HOLD_V);

    assert_cal_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |=> !cal_start);

    assert_cal_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> gain_lock && hw_mute);

    assert_lock_muted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gain_lock |-> hw_mute);

    assert_zero_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gain_zero |-> !hw_mute && !gain_lock && $past(gain_lock) && !$past(core_reset));

    assert_zero_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gain_zero |=> !gain_zero);

    assert_undervolt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> core_reset && hw_mute);

    assert_mute_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start && !$past(core_reset) |-> low_run_q >= MUTE_V);

    assert_muted_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_mute && !gain_lock && supply_ok && !mute_n |=> hw_mute && !gain_zero);

endmodule

bind pwr_mute_seq pwr_mute_seq_chk #(
    .HOLD_CYCLES     (HOLD_CYCLES),
    .MUTE_MIN_CYCLES (MUTE_MIN_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok_i),
    .mute_n     (mute_n_i),
    .hw_mute    (hw_mute_o),
    .core_reset (core_reset_o),
    .gain_lock  (gain_lock_o),
    .cal_start  (cal_start_o),
    .gain_zero  (gain_zero_o)
);

// File: tb/tb_pwr_mute_seq.sv
`timescale 1ns/1ps
module tb_pwr_mute_seq;
    localparam int H = 20;
    localparam int M = 6;

    logic clk = 1'b0;
    logic rst_n, supply_ok, mute_n, cal_done;
    logic hw_mute, core_reset, gain_lock, cal_start, gain_zero;
    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwr_mute_seq #(.HOLD_CYCLES(H), .MUTE_MIN_CYCLES(M)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok_i  (supply_ok),
        .mute_n_i     (mute_n),
        .cal_done_i   (cal_done),
        .hw_mute_o    (hw_mute),
        .core_reset_o (core_reset),
        .gain_lock_o  (gain_lock),
        .cal_start_o  (cal_start),
        .gain_zero_o  (gain_zero)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_to_cal(input string req);
        int n = 0;
        int bad = 0;
        while (n < 4 * H) begin
            step();
            n++;
            if (cal_start) break;
            if (!hw_mute || !core_reset) bad++;
        end
        chk({req, " hold length"}, n, H);
        chk({req, " hold kept reset and mute"}, bad, 0);
        chk({req, " reset released at cal start"}, int'(core_reset), 0);
        chk({req, " mute held at cal start"}, int'(hw_mute), 1);
    endtask

    // R2/R3/R4: finish the start-up calibration
    task automatic finish_pcal();
        for (int i = 0; i < 2; i++) begin
            step();
            chk("R2 cal start single cycle", int'(cal_start), 0);
            chk("R3 lock during cal", int'(gain_lock && hw_mute), 1);
        end
        cal_done = 1'b1;
        step();
        cal_done = 1'b0;
        chk("R4 gain zero pulse", int'(gain_zero), 1);
        chk("R4 mute released", int'(hw_mute), 0);
        chk("R4 lock released", int'(gain_lock), 0);
        step();
        chk("R4 gain zero one cycle", int'(gain_zero), 0);
    endtask

    // R6: qualify a mute of exactly M edges
    task automatic mute_qualify();
        mute_n = 1'b0;
        for (int i = 1; i <= M; i++) begin
            step();
            chk("R6 cal start at qualifying edge", int'(cal_start), int'(i == M));
            chk("R6 mute at qualifying edge", int'(hw_mute), int'(i == M));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; supply_ok = 1'b1; mute_n = 1'b1; cal_done = 1'b0;
        step(); step();
        chk("R1 reset state mute", int'(hw_mute), 1);
        chk("R1 reset state core reset", int'(core_reset), 1);
        chk("R1 reset state pulses", int'(cal_start || gain_zero), 0);
        rst_n = 1'b1;

        count_to_cal("R1");
        finish_pcal();

        // R7: every short width, then two short pulses split by one high cycle
        for (int w = 1; w < M; w++) begin
            int seen = 0;
            mute_n = 1'b0;
            for (int i = 0; i < w; i++) begin
                step();
                if (cal_start || hw_mute) seen++;
            end
            mute_n = 1'b1;
            for (int i = 0; i < M + 1; i++) begin
                step();
                if (cal_start || hw_mute) seen++;
            end
            chk("R7 short mute ignored", seen, 0);
        end
        begin
            int seen = 0;
            mute_n = 1'b0;
            for (int i = 0; i < M - 1; i++) begin step(); if (cal_start || hw_mute) seen++; end
            mute_n = 1'b1;
            step(); if (cal_start || hw_mute) seen++;
            mute_n = 1'b0;
            for (int i = 0; i < M - 1; i++) begin step(); if (cal_start || hw_mute) seen++; end
            mute_n = 1'b1;
            for (int i = 0; i < M + 1; i++) begin step(); if (cal_start || hw_mute) seen++; end
            chk("R7 split short pulses ignored", seen, 0);
        end

        // R6/R3/R8: qualified mute, pin held low through calibration
        mute_qualify();
        for (int i = 0; i < 2; i++) begin
            step();
            chk("R3 mute cal lock", int'(gain_lock && hw_mute), 1);
            chk("R2 mute cal start single", int'(cal_start), 0);
        end
        cal_done = 1'b1;
        step();
        cal_done = 1'b0;
        chk("R8 muted after cal", int'(hw_mute), 1);
        chk("R8 no gain zero after mute cal", int'(gain_zero), 0);
        chk("R8 lock released after mute cal", int'(gain_lock), 0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R8 mute held while pin low", int'(hw_mute), 1);
        end
        mute_n = 1'b1;
        step();
        chk("R8 unmute on release", int'(hw_mute), 0);
        chk("R8 no gain zero on release", int'(gain_zero), 0);

        // R8: pin released during calibration
        mute_qualify();
        mute_n = 1'b1;
        step(); step();
        chk("R3 lock after early release", int'(gain_lock), 1);
        cal_done = 1'b1;
        step();
        cal_done = 1'b0;
        chk("R8 direct return", int'(hw_mute), 0);
        chk("R8 direct return no zero", int'(gain_zero), 0);

        // R5: drop in normal operation, then at every hold position, then in calibration
        for (int c = 0; c < H; c++) begin
            supply_ok = 1'b0;
            step();
            chk("R5 drop forces hold", int'(core_reset && hw_mute), 1);
            supply_ok = 1'b1;
            for (int i = 0; i < c; i++) step();
            supply_ok = 1'b0;
            step();
            chk("R5 drop inside hold", int'(core_reset && hw_mute), 1);
            supply_ok = 1'b1;
            count_to_cal("R5");
        end
        finish_pcal();

        // R5: drop while muted
        mute_qualify();
        step();
        cal_done = 1'b1;
        step();
        cal_done = 1'b0;
        chk("R8 muted before drop", int'(hw_mute && !gain_lock), 1);
        supply_ok = 1'b0;
        step();
        chk("R5 drop from muted", int'(core_reset && hw_mute), 1);
        mute_n = 1'b1;
        supply_ok = 1'b1;
        count_to_cal("R5 from muted");
        finish_pcal();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule